// File: doc/BRIEF.md
# Predicate Mask Builder

This block turns a compact mask-mode field into a 64-bit predicate mask for a vectorised instruction. A caller hands over a request made of a source-kind flag (integer or condition register), a three-bit mode, a vector length and a base condition-field index. The block then either answers at once with an all-ones mask or fetches what it needs from the register files over two simple read ports. Each read port returns data one cycle after the request.

In integer mode one general register is read. Its value is passed through unchanged, complemented, or used as a shift amount that places a single set bit. In condition-register mode the block walks the condition fields one element at a time. It picks one flag bit from each field, can invert that bit, and places it at the element's position. The finished mask is held behind a valid/ready pair until the consumer takes it. The caller only issues requests while vector-prefix execution is enabled.

Top module: `pred_mask_builder`

## Requirements
- R1: While rst_ni is low, mask_valid_o, int_rd_req_o and cr_rd_req_o are 0 and req_ready_o is 1.
- R2: An integer request with mode 0 gives an all-ones mask with no register read, and mask_valid_o is high right after the accepting edge.
- R3: Integer modes 1 to 7 each issue exactly one general-register read, for one cycle, in the cycle after acceptance. The read address is 3 for modes 1 to 3, 10 for modes 4 and 5, and 30 for modes 6 and 7. Read data is taken the cycle after the request, and mask_valid_o rises two edges after the accepting edge.
- R4: Integer modes 2, 4 and 6 give the register value unchanged.
- R5: Integer modes 3, 5 and 7 give the bitwise complement of the register value.
- R6: Integer mode 1 gives a mask with only bit n set, where n is bits [5:0] of the register value.
- R7: A condition request reads N = min(vl, 64) fields, one per cycle on consecutive cycles, at indices base, base+1, and so on, modulo 128. mask_valid_o rises N+1 edges after the accepting edge.
- R8: In condition mode, bit k of the mask is a flag of the field read for element k, selected by mode[2:1]: 0 takes field bit 3, 1 takes bit 2, 2 takes bit 1, and 3 takes bit 0. The flag is inverted when mode[0] is 1. Mask bits at and above N are 0.
- R9: A condition request with vl = 0 issues no read and gives an all-zero mask, with mask_valid_o high right after the accepting edge.
- R10: While mask_valid_o is high and mask_ready_i is low, mask_valid_o stays high and mask_o does not change.
- R11: req_ready_o is 1 when idle, and also when a mask is pending and mask_ready_i is 1. A request accepted in the handoff cycle starts at once. After a handoff with no new request, mask_valid_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_cr_i | input | 1 | 1 = condition-register source, 0 = integer source |
| req_mode_i | input | 3 | Mask-mode field |
| req_vl_i | input | 7 | Vector length (values above 64 are treated as 64) |
| req_cr_base_i | input | 7 | First condition-field index |
| int_rd_req_o | output | 1 | General-register read strobe |
| int_rd_addr_o | output | 5 | General-register number |
| int_rd_data_i | input | 64 | Register value, one cycle after the strobe |
| cr_rd_req_o | output | 1 | Condition-field read strobe |
| cr_rd_idx_o | output | 7 | Condition-field index |
| cr_rd_data_i | input | 4 | Field value, one cycle after the strobe |
| mask_valid_o | output | 1 | Mask present |
| mask_ready_i | input | 1 | Consumer takes the mask |
| mask_o | output | 64 | Predicate mask |

## Verification
The mask handoff and the acceptance of the next request can fall in the same edge. The new request must then overwrite the old mask only after the consumer has taken it. The bench provokes this by raising mask_ready_i and req_valid_i together in the cycle the previous mask is shown, both in directed cases and at random. It judges the outcome by checking that req_ready_o is high in that cycle and that the second mask, its latency and its read count match the expected values.

// File: rtl/pred_mask_pkg.sv
`timescale 1ns/1ps
package pred_mask_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INT_REQ, ST_INT_WAIT, ST_CR_RD, ST_DONE
  } pm_state_e;

  // flag picked from a 4-bit condition field
  typedef enum logic [1:0] {
    CR_LT = 2'd0, CR_GT = 2'd1, CR_EQ = 2'd2, CR_SO = 2'd3
  } cr_flag_e;

  typedef struct packed {
    logic all_ones;
    logic invert;
    logic unary;
  } int_ctl_t;
endpackage

// File: rtl/pred_int_decode.sv
`timescale 1ns/1ps
module pred_int_decode
  import pred_mask_pkg::*;
#(
  parameter int unsigned GPR_AW = 5,
  parameter int unsigned REG_A  = 3,
  parameter int unsigned REG_B  = 10,
  parameter int unsigned REG_C  = 30
) (
  input  logic [2:0]        mode_i,
  output int_ctl_t          ctl_o,
  output logic [GPR_AW-1:0] addr_o
);
  always_comb begin
    ctl_o.all_ones = (mode_i == 3'd0);
    ctl_o.unary    = (mode_i == 3'd1);
    ctl_o.invert   = (mode_i >= 3'd3) && mode_i[0];
    unique case (mode_i[2:1])
      2'd2:    addr_o = GPR_AW'(REG_B);
      2'd3:    addr_o = GPR_AW'(REG_C);
      default: addr_o = GPR_AW'(REG_A);
    endcase
  end
endmodule

// File: rtl/pred_int_post.sv
`timescale 1ns/1ps
module pred_int_post #(
  parameter int unsigned MASK_W = 64
) (
  input  logic [MASK_W-1:0] data_i,
  input  logic              invert_i,
  input  logic              unary_i,
  output logic [MASK_W-1:0] mask_o
);
  localparam int unsigned SH_W = $clog2(MASK_W);
  localparam logic [MASK_W-1:0] ONE = MASK_W'(1);

  always_comb begin
    if (unary_i)       mask_o = ONE << data_i[SH_W-1:0];
    else if (invert_i) mask_o = ~data_i;
    else               mask_o = data_i;
  end
endmodule

// File: rtl/pred_cr_pick.sv
`timescale 1ns/1ps
module pred_cr_pick
  import pred_mask_pkg::*;
(
  input  logic [3:0] field_i,
  input  cr_flag_e   sel_i,
  input  logic       invert_i,
  output logic       bit_o
);
  logic raw;
  always_comb begin
    unique case (sel_i)
      CR_LT:   raw = field_i[3];
      CR_GT:   raw = field_i[2];
      CR_EQ:   raw = field_i[1];
      default: raw = field_i[0];
    endcase
    bit_o = raw ^ invert_i;
  end
endmodule

// File: rtl/pred_mask_builder.sv
`timescale 1ns/1ps
module pred_mask_builder
  import pred_mask_pkg::*;
#(
  parameter int unsigned MASK_W = 64,
  parameter int unsigned GPR_AW = 5,
  parameter int unsigned CR_IW  = 7,
  parameter int unsigned VL_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_cr_i,
  input  logic [2:0]        req_mode_i,
  input  logic [VL_W-1:0]   req_vl_i,
  input  logic [CR_IW-1:0]  req_cr_base_i,
  output logic              int_rd_req_o,
  output logic [GPR_AW-1:0] int_rd_addr_o,
  input  logic [MASK_W-1:0] int_rd_data_i,
  output logic              cr_rd_req_o,
  output logic [CR_IW-1:0]  cr_rd_idx_o,
  input  logic [3:0]        cr_rd_data_i,
  output logic              mask_valid_o,
  input  logic              mask_ready_i,
  output logic [MASK_W-1:0] mask_o
);
  localparam int unsigned SH_W = $clog2(MASK_W);
  localparam logic [VL_W-1:0] VL_MAX = VL_W'(MASK_W);

  pm_state_e         state_q;
  logic [2:0]        mode_q;
  logic [VL_W-1:0]   vl_q, cnt_q;
  logic [CR_IW-1:0]  base_q;
  logic [GPR_AW-1:0] addr_q;
  logic              inv_q, unary_q;
  logic              pend_q;
  logic [SH_W-1:0]   pend_idx_q;
  logic [MASK_W-1:0] mask_q;

  int_ctl_t          dec_ctl;
  logic [GPR_AW-1:0] dec_addr;
  logic [MASK_W-1:0] int_mask;
  logic              cr_bit;
  logic [VL_W-1:0]   vl_eff;
  logic              accept;

  pred_int_decode #(.GPR_AW(GPR_AW)) i_dec (
    .mode_i(req_mode_i), .ctl_o(dec_ctl), .addr_o(dec_addr)
  );

  pred_int_post #(.MASK_W(MASK_W)) i_post (
    .data_i(int_rd_data_i), .invert_i(inv_q), .unary_i(unary_q), .mask_o(int_mask)
  );

  pred_cr_pick i_pick (
    .field_i(cr_rd_data_i), .sel_i(cr_flag_e'(mode_q[2:1])),
    .invert_i(mode_q[0]), .bit_o(cr_bit)
  );

  assign vl_eff       = (req_vl_i > VL_MAX) ? VL_MAX : req_vl_i;
  assign req_ready_o  = (state_q == ST_IDLE) || ((state_q == ST_DONE) && mask_ready_i);
  assign accept       = req_valid_i && req_ready_o;
  assign int_rd_req_o = (state_q == ST_INT_REQ);
  assign int_rd_addr_o = addr_q;
  assign cr_rd_req_o  = (state_q == ST_CR_RD) && (cnt_q < vl_q);
  assign cr_rd_idx_o  = base_q + CR_IW'(cnt_q);
  assign mask_valid_o = (state_q == ST_DONE);
  assign mask_o       = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= '0;
      vl_q       <= '0;
      cnt_q      <= '0;
      base_q     <= '0;
      addr_q     <= '0;
      inv_q      <= 1'b0;
      unary_q    <= 1'b0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      mask_q     <= '0;
    end else begin
      // condition reads are pipelined: issue one, collect the previous
      pend_q <= cr_rd_req_o;
      if (cr_rd_req_o) begin
        pend_idx_q <= cnt_q[SH_W-1:0];
        cnt_q      <= cnt_q + VL_W'(1);
      end
      if (pend_q) mask_q[pend_idx_q] <= cr_bit;

      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            mode_q  <= req_mode_i;
            vl_q    <= vl_eff;
            base_q  <= req_cr_base_i;
            addr_q  <= dec_addr;
            inv_q   <= dec_ctl.invert;
            unary_q <= dec_ctl.unary;
            cnt_q   <= '0;
            if (req_cr_i) begin
              mask_q  <= '0;
              state_q <= (vl_eff == '0) ? ST_DONE : ST_CR_RD;
            end else if (dec_ctl.all_ones) begin
              mask_q  <= '1;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_INT_REQ;
            end
          end else if ((state_q == ST_DONE) && mask_ready_i) begin
            state_q <= ST_IDLE;
          end
        end
        ST_INT_REQ:  state_q <= ST_INT_WAIT;
        ST_INT_WAIT: begin
          mask_q  <= int_mask;
          state_q <= ST_DONE;
        end
        ST_CR_RD: if (!cr_rd_req_o) state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pred_mask_chk.sv
`timescale 1ns/1ps
module pred_mask_chk #(
  parameter int unsigned MASK_W = 64,
  parameter int unsigned CR_IW  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              int_rd_req_o,
  input logic              cr_rd_req_o,
  input logic [CR_IW-1:0]  cr_rd_idx_o,
  input logic              mask_valid_o,
  input logic              mask_ready_i,
  input logic [MASK_W-1:0] mask_o
);
  a_r10_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_valid_o && !mask_ready_i) |=> (mask_valid_o && $stable(mask_o)));

  a_r3_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rd_req_o |=> !int_rd_req_o);

  a_r7_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_rd_req_o ##1 cr_rd_req_o) |-> (cr_rd_idx_o == CR_IW'($past(cr_rd_idx_o) + 1'b1)));

  a_r11_one_activity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({int_rd_req_o, cr_rd_req_o, mask_valid_o}));

  a_r11_ready_on_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_valid_o && mask_ready_i) |-> req_ready_o);
endmodule

bind pred_mask_builder pred_mask_chk #(.MASK_W(MASK_W), .CR_IW(CR_IW)) i_pred_mask_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .int_rd_req_o(int_rd_req_o), .cr_rd_req_o(cr_rd_req_o), .cr_rd_idx_o(cr_rd_idx_o),
  .mask_valid_o(mask_valid_o), .mask_ready_i(mask_ready_i), .mask_o(mask_o)
);

// File: tb/test_pred_mask_builder.sv
`timescale 1ns/1ps
module test_pred_mask_builder;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic        req_valid_i = 1'b0, req_ready_o, req_cr_i = 1'b0;
  logic [2:0]  req_mode_i = '0;
  logic [6:0]  req_vl_i = '0, req_cr_base_i = '0;
  logic        int_rd_req_o, cr_rd_req_o, mask_valid_o, mask_ready_i = 1'b0;
  logic [4:0]  int_rd_addr_o;
  logic [63:0] int_rd_data_i = '0, mask_o;
  logic [6:0]  cr_rd_idx_o;
  logic [3:0]  cr_rd_data_i = '0;

  pred_mask_builder i_pred_mask_builder (.*);

  logic [63:0] gpr [32];
  logic [3:0]  crf [128];
  int n_tests = 0, n_fail = 0;
  int int_total = 0, cr_total = 0;
  logic [6:0] cr_log [1024];

  // register file models: one-cycle read latency
  always @(posedge clk_i) begin
    if (int_rd_req_o) int_rd_data_i <= gpr[int_rd_addr_o];
    if (cr_rd_req_o)  cr_rd_data_i  <= crf[cr_rd_idx_o];
  end

  always @(negedge clk_i) if (rst_ni) begin
    if (int_rd_req_o) int_total++;
    if (cr_rd_req_o) begin
      cr_log[cr_total % 1024] = cr_rd_idx_o;
      cr_total++;
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_int(input logic [2:0] m);
    case (m)
      3'd0: return '1;
      3'd1: return 64'd1 << gpr[3][5:0];
      3'd2: return gpr[3];
      3'd3: return ~gpr[3];
      3'd4: return gpr[10];
      3'd5: return ~gpr[10];
      3'd6: return gpr[30];
      default: return ~gpr[30];
    endcase
  endfunction

  function automatic logic [63:0] exp_cr(input logic [2:0] m, input int vl, input int base);
    logic [63:0] r = '0;
    int n = (vl > 64) ? 64 : vl;
    for (int k = 0; k < n; k++) begin
      logic [3:0] f = crf[(base + k) % 128];
      r[k] = f[3 - int'(m[2:1])] ^ m[0];
    end
    return r;
  endfunction

  // one transaction; b2b raises mask_ready_i together with the new request
  task automatic run(input logic cr, input logic [2:0] m, input int vl, input int base,
                     input int stall, input bit b2b, input bit keep);
    logic [63:0] exp;
    int n, exp_lat, exp_ir, exp_cn, lat, s_ir, s_cr;
    string tg;
    n       = (vl > 64) ? 64 : vl;
    exp     = cr ? exp_cr(m, vl, base) : exp_int(m);
    exp_lat = cr ? ((n == 0) ? 0 : n + 1) : ((m == 3'd0) ? 0 : 2);
    exp_ir  = (!cr && m != 3'd0) ? 1 : 0;
    exp_cn  = cr ? n : 0;
    tg = cr ? $sformatf("R8 cr m=%0d vl=%0d", m, vl) :
              (m == 0 ? "R2 int m=0" : m == 1 ? "R6 unary" :
               m[0] ? $sformatf("R5 inv m=%0d", m) : $sformatf("R4 plain m=%0d", m));
    @(negedge clk_i);
    req_valid_i = 1'b1; req_cr_i = cr; req_mode_i = m;
    req_vl_i = 7'(vl); req_cr_base_i = 7'(base);
    if (b2b) mask_ready_i = 1'b1;
    #1;
    if (b2b) chk("R11 ready on handoff", req_ready_o, 1);
    while (!req_ready_o) begin @(negedge clk_i); #1; end
    s_ir = int_total; s_cr = cr_total;
    @(posedge clk_i); #1;
    req_valid_i = 1'b0; mask_ready_i = 1'b0;
    lat = 0;
    while (!mask_valid_o && lat < 300) begin @(posedge clk_i); #1; lat++; end
    chk(tg, mask_o, exp);
    chk(cr ? (n == 0 ? "R9 latency" : "R7 latency") : "R3 latency", 64'(lat), 64'(exp_lat));
    chk("R3 int read count", 64'(int_total - s_ir), 64'(exp_ir));
    chk(n == 0 && cr ? "R9 cr read count" : "R7 cr read count", 64'(cr_total - s_cr), 64'(exp_cn));
    if (cr) begin
      int bad = 0;
      for (int k = s_cr; k < cr_total; k++)
        if (cr_log[k % 1024] != 7'((base + k - s_cr) % 128)) bad++;
      chk("R7 cr index order", 64'(bad), 64'd0);
    end
    for (int s = 0; s < stall; s++) begin
      @(posedge clk_i); #1;
      chk("R10 hold", {mask_valid_o, mask_o}, {1'b1, exp});
    end
    if (!keep) begin
      @(negedge clk_i); mask_ready_i = 1'b1;
      @(posedge clk_i); #1; mask_ready_i = 1'b0;
      chk("R11 drop after handoff", mask_valid_o, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F0C_5EED));
    for (int i = 0; i < 32; i++) gpr[i] = {$urandom, $urandom};
    for (int i = 0; i < 128; i++) crf[i] = 4'($urandom);
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset valid", mask_valid_o, 0);
    chk("R1 reset ready", req_ready_o, 1);
    chk("R1 reset reads", {int_rd_req_o, cr_rd_req_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int m = 0; m < 8; m++) run(1'b0, 3'(m), 0, 0, m % 3, 1'b0, 1'b0);
    gpr[3] = 64'd63; run(1'b0, 3'd1, 0, 0, 0, 1'b0, 1'b0);
    gpr[3] = 64'hFFFF_FFFF_FFFF_FFC0; run(1'b0, 3'd1, 0, 0, 0, 1'b0, 1'b0);
    run(1'b1, 3'd2, 0, 5, 1, 1'b0, 1'b0);
    run(1'b1, 3'd0, 1, 9, 0, 1'b0, 1'b0);
    for (int m = 0; m < 8; m++) run(1'b1, 3'(m), 64, 0, 0, 1'b0, 1'b0);
    run(1'b1, 3'd7, 100, 120, 2, 1'b0, 1'b0);
    run(1'b1, 3'd4, 20, 110, 0, 1'b0, 1'b1);
    run(1'b0, 3'd5, 0, 0, 0, 1'b1, 1'b1);
    run(1'b0, 3'd0, 0, 0, 0, 1'b1, 1'b1);
    run(1'b1, 3'd3, 0, 0, 0, 1'b1, 1'b1);
    run(1'b1, 3'd6, 7, 30, 0, 1'b1, 1'b0);

    for (int i = 0; i < 60; i++) begin
      bit keep = 1'($urandom);
      gpr[3] = {$urandom, $urandom};
      run(1'($urandom), 3'($urandom), int'($urandom % 80), int'($urandom % 128),
          int'($urandom % 3), 1'b0, keep);
      if (keep) run(1'($urandom), 3'($urandom), int'($urandom % 70), int'($urandom % 128),
                    0, 1'b1, 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule